// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC. It decides whether a frame should be kept by looking only at its 48-bit destination address. The address arrives one byte per transfer on a valid/ready byte stream, and a start-of-frame flag marks the first byte. While the six bytes stream in, the block runs the Ethernet CRC-32 over them. One cycle after the sixth byte it gives a single verdict pulse that says accept or reject.

Software programs the filter through a simple write port:

| Address | Register | Contents |
|---------|----------|----------|
| 0 | control | bit 0 promiscuous, bit 1 pass-all-multicast, bit 2 hash-plus-perfect, bit 3 broadcast disable |
| 1 | station word 0 | low four station address bytes |
| 2 | station word 1 | top two station address bytes |
| 3 | hash low | 32 hash bins |
| 4 | hash high | 32 hash bins |

Unicast destinations are matched exactly against the station address. Multicast destinations go through a 64-bin hash. The hash is indexed by the top six bits of the address CRC. A configuration written at any moment is copied into the working set only when a frame starts, so each verdict uses one consistent configuration.

The input stream never applies back-pressure: `in_ready` is held high, and every cycle with `in_valid` high transfers one byte. Bytes that arrive after the sixth address byte, or before any start-of-frame, are the frame body and are ignored. The verdict has no ready signal. The receiver must sample it in its one-cycle pulse.

Top module: `daf_top`

## Requirements
- R1: `in_ready` is high in every cycle, and a byte is transferred in every cycle where `in_valid` is high. `in_valid` low for any number of cycles between address bytes does not change the verdict.
- R2: A transfer with `in_sof` high is byte 0 of a new address. It restarts the byte count and the CRC, even in the middle of an address. Transfers after byte 5, or with no start-of-frame since reset, are ignored and produce no verdict.
- R3: `vd_valid` is high for exactly one cycle, the cycle after the sixth address byte is transferred. There is exactly one pulse per complete address. Outside the pulse `vd_accept` is low.
- R4: The CRC uses the reflected polynomial 0xEDB88320, preset to all ones, with each byte processed least significant bit first and no final inversion. The hash index is CRC bits 31..26. Index bit 5 set selects the hash high register (address 4) and clear selects hash low (address 3). Index bits 4..0 select the bit within that register.
- R5: With control bit 0 (promiscuous) set, every address is accepted.
- R6: With control bit 1 (pass-all-multicast) set, every multicast address is accepted. An address is multicast when bit 0 of its byte 0 is 1.
- R7: With control bit 2 (hash-plus-perfect) set, a non-broadcast multicast address is accepted only if its indexed hash bit is 1.
- R8: A unicast address is accepted, outside promiscuous mode, only when it equals the station address.
  - Byte 0 through byte 3 sit in bits 7..0, 15..8, 23..16 and 31..24 of address 1.
  - Byte 4 sits in bits 7..0 of address 2, and byte 5 in bits 15..8 of address 2.
- R9: The all-ones broadcast address is accepted unless control bit 3 is set, in which case it is rejected outside promiscuous mode. With no control bits set, a multicast that is not broadcast is rejected.
- R10: A register write made while an address is streaming does not affect that address's verdict. It takes effect from the next start-of-frame.
- R11: After reset `vd_valid` and `vd_accept` are low, and all registers are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Address byte valid |
| in_ready | output | 1 | Byte accepted (always high) |
| in_sof | input | 1 | Byte is byte 0 of a new frame |
| in_data | input | 8 | Address byte |
| vd_valid | output | 1 | Verdict pulse |
| vd_accept | output | 1 | Verdict value, 1 = accept |

## Verification
The hardest cases to reach from the ports are individual hash bins. The bin depends on a CRC of the whole address, so no address pattern picks a bin by inspection. The bench computes the CRC of candidate multicast addresses itself. It then programs a single bin, either in the correct register or at the same position in the other register, which separates acceptance by index from acceptance by register choice.

Two timing cases are also driven on purpose:
- A configuration write placed between the third and fourth byte of an address, to check that the new setting waits for the next frame.
- A fresh start-of-frame after four bytes, to check that the abandoned address never yields a verdict.

// File: rtl/daf_pkg.sv
`timescale 1ns/1ps
package daf_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = BYTE_W * ADDR_BYTES;
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
  localparam int CRC_W      = 32;
  localparam int HASH_IDX_W = 6;
  localparam int HASH_BINS  = 1 << HASH_IDX_W;
  localparam int REG_W      = 32;
  localparam int REG_AW     = 3;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

  localparam logic [REG_AW-1:0] RA_MODE   = 3'd0;
  localparam logic [REG_AW-1:0] RA_STA_LO = 3'd1;
  localparam logic [REG_AW-1:0] RA_STA_HI = 3'd2;
  localparam logic [REG_AW-1:0] RA_HSH_LO = 3'd3;
  localparam logic [REG_AW-1:0] RA_HSH_HI = 3'd4;

  typedef struct packed {
    logic bcast_off;
    logic hash_perf;
    logic all_multi;
    logic promisc;
  } mode_t;

  typedef struct packed {
    mode_t                  mode;
    logic [ADDR_W-1:0]      station;
    logic [HASH_BINS-1:0]   hash;
  } filt_cfg_t;
endpackage

// File: rtl/daf_regs.sv
`timescale 1ns/1ps
module daf_regs
  import daf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              load,
  output filt_cfg_t         act
);
  localparam int MODE_W = $bits(mode_t);
  localparam int STA_HI_W = ADDR_W - REG_W;
  localparam int HALF_H = HASH_BINS / 2;

  filt_cfg_t stg;

  // staged copy, written by software at any time
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg <= '0;
    end else if (we) begin
      case (addr)
        RA_MODE:   stg.mode <= mode_t'(wdata[MODE_W-1:0]);
        RA_STA_LO: stg.station[REG_W-1:0] <= wdata;
        RA_STA_HI: stg.station[ADDR_W-1:REG_W] <= wdata[STA_HI_W-1:0];
        RA_HSH_LO: stg.hash[HALF_H-1:0] <= wdata[HALF_H-1:0];
        RA_HSH_HI: stg.hash[HASH_BINS-1:HALF_H] <= wdata[HALF_H-1:0];
        default: ;
      endcase
    end
  end

  // working copy, frozen for the duration of one address
  always_ff @(posedge clk) begin
    if (!rst_n) act <= '0;
    else if (load) act <= stg;
  end
endmodule

// File: rtl/daf_crc.sv
`timescale 1ns/1ps
module daf_crc #(
  parameter int CRC_W = 32,
  parameter int DW    = 8,
  parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [DW-1:0]    data,
  output logic [CRC_W-1:0] crc_nxt
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_in;

  function automatic logic [CRC_W-1:0] step(input logic [CRC_W-1:0] c,
                                            input logic [DW-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < DW; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  assign crc_in  = restart ? '1 : crc_q;
  assign crc_nxt = step(crc_in, data);

  always_ff @(posedge clk) begin
    if (!rst_n)  crc_q <= '1;
    else if (en) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/daf_track.sv
`timescale 1ns/1ps
module daf_track
  import daf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              sof,
  input  logic [BYTE_W-1:0] data,
  output logic              active,
  output logic              last,
  output logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] addr_full
);
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] idx;
  logic             in_frame;

  assign idx      = sof ? '0 : cnt;
  assign in_frame = sof || (cnt < IDLE);
  assign active   = take && in_frame;
  assign last     = active && (idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= IDLE;
    else if (active) cnt <= idx + 1'b1;
  end

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    logic              hit;
    assign hit = active && (idx == CNT_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)   byte_q <= '0;
      else if (hit) byte_q <= data;
    end
    assign addr_full[i*BYTE_W +: BYTE_W] = hit ? data : byte_q;
  end
endmodule

// File: rtl/daf_decide.sv
`timescale 1ns/1ps
module daf_decide
  import daf_pkg::*;
(
  input  filt_cfg_t         cfg,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CRC_W-1:0]  crc,
  output logic              accept
);
  logic                  is_bcast;
  logic                  is_mcast;
  logic                  sta_hit;
  logic [HASH_IDX_W-1:0] bin;
  logic                  bin_set;

  always_comb begin
    is_bcast = &addr;
    is_mcast = addr[0];
    sta_hit  = (addr == cfg.station);
    bin      = crc[CRC_W-1 -: HASH_IDX_W];
    bin_set  = cfg.hash[bin];
    accept   = cfg.mode.promisc
             | (is_bcast & ~cfg.mode.bcast_off)
             | (is_mcast & ~is_bcast &
                (cfg.mode.all_multi | (cfg.mode.hash_perf & bin_set)))
             | (~is_mcast & sta_hit);
  end
endmodule

// File: rtl/daf_top.sv
`timescale 1ns/1ps
module daf_top
  import daf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sof,
  input  logic [BYTE_W-1:0] in_data,
  output logic              vd_valid,
  output logic              vd_accept
);
  filt_cfg_t         act_cfg;
  logic              take;
  logic              active;
  logic              last;
  logic [CNT_W-1:0]  byte_cnt;
  logic [ADDR_W-1:0] addr_full;
  logic [CRC_W-1:0]  crc_nxt;
  logic              accept;

  assign in_ready = 1'b1;
  assign take     = in_valid && in_ready;

  daf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .load(take && in_sof), .act(act_cfg)
  );

  daf_track u_track (
    .clk(clk), .rst_n(rst_n), .take(take), .sof(in_sof), .data(in_data),
    .active(active), .last(last), .cnt(byte_cnt), .addr_full(addr_full)
  );

  daf_crc #(.CRC_W(CRC_W), .DW(BYTE_W), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .en(active), .restart(in_sof),
    .data(in_data), .crc_nxt(crc_nxt)
  );

  daf_decide u_decide (
    .cfg(act_cfg), .addr(addr_full), .crc(crc_nxt), .accept(accept)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vd_valid  <= 1'b0;
      vd_accept <= 1'b0;
    end else begin
      vd_valid  <= last;
      vd_accept <= last && accept;
    end
  end
endmodule

// File: rtl/daf_checks.sv
`timescale 1ns/1ps
module daf_checks
  import daf_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic             vd_valid,
  input logic             vd_accept,
  input logic [CNT_W-1:0] cnt,
  input filt_cfg_t        act_cfg
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

  // R3: the verdict lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vd_valid |=> !vd_valid);

  // R3: the final address byte yields a verdict on the next cycle
  a_r3_verdict_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sof && cnt == LAST) |=> vd_valid);

  // R3: the accept flag is low outside the pulse
  a_r3_accept_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !vd_valid |-> !vd_accept);

  // R2: a start-of-frame byte never completes an address
  a_r2_sof_no_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> !vd_valid);

  // R5: promiscuous mode accepts everything
  a_r5_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_valid && act_cfg.mode.promisc) |-> vd_accept);

  // R10: the working configuration changes only at start-of-frame
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_sof) |=> $stable(act_cfg));
endmodule

bind daf_top daf_checks u_checks (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .vd_valid(vd_valid), .vd_accept(vd_accept), .cnt(byte_cnt),
  .act_cfg(act_cfg)
);

// File: tb/daf_top_test.sv
`timescale 1ns/1ps
module daf_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        vd_valid;
  logic        vd_accept;

  int n_chk = 0;
  int n_bad = 0;
  int pulses = 0;
  bit finished = 0;

  // bench model of programmed state
  logic [3:0]  m_mode = '0;
  logic [47:0] m_sta = '0;
  logic [63:0] m_hash = '0;

  always #4 clk = ~clk;

  daf_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_data(in_data), .vd_valid(vd_valid),
    .vd_accept(vd_accept)
  );

  always @(negedge clk) if (rst_n && vd_valid) pulses++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_of(input logic [47:0] a);
    logic [31:0] c = '1;
    for (int i = 0; i < 48; i++) begin
      if (c[0] ^ a[i]) c = (c >> 1) ^ 32'hEDB88320;
      else             c = c >> 1;
    end
    return c;
  endfunction

  function automatic bit model(input logic [47:0] a);
    bit bc = &a;
    bit mc = a[0];
    logic [5:0] ix = crc_of(a)[31:26];
    if (m_mode[0]) return 1;
    if (bc) return !m_mode[3];
    if (mc) return m_mode[1] || (m_mode[2] && m_hash[ix]);
    return a == m_sta;
  endfunction

  task automatic wr(input logic [2:0] ad, input logic [31:0] d);
    @(negedge clk);
    in_valid = 0; in_sof = 0;
    cfg_we = 1; cfg_addr = ad; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (ad)
      3'd0: m_mode = d[3:0];
      3'd1: m_sta[31:0] = d;
      3'd2: m_sta[47:32] = d[15:0];
      3'd3: m_hash[31:0] = d;
      3'd4: m_hash[63:32] = d;
      default: ;
    endcase
  endtask

  task automatic put(input logic [7:0] d, input bit sof);
    @(negedge clk);
    in_valid = 1; in_sof = sof; in_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_sof = 0;
    end
  endtask

  // sample the verdict of the byte just driven, then confirm a single pulse
  task automatic finish(input bit exp, input string tag);
    int p0;
    p0 = pulses;
    @(posedge clk); #1;
    check(vd_valid === 1'b1 && vd_accept === exp, tag, {vd_valid, vd_accept}, {1'b1, exp});
    idle(2);
    check(pulses == p0 + 1, {tag, " pulse count"}, pulses - p0, 1);
  endtask

  task automatic frame(input logic [47:0] a, input int gap, input bit exp, input string tag);
    for (int b = 0; b < 6; b++) begin
      put(a[8*b +: 8], b == 0);
      if (b < 5 && gap > 0) idle(gap);
    end
    finish(exp, tag);
  endtask

  task automatic frame_m(input logic [47:0] a, input string tag);
    frame(a, 0, model(a), tag);
  endtask

  task automatic set_sta(input logic [47:0] s);
    wr(3'd1, s[31:0]);
    wr(3'd2, {16'h0, s[47:32]});
  endtask

  localparam logic [47:0] STA  = 48'h665544332210;
  localparam logic [47:0] UNI2 = 48'h665544332212;
  localparam logic [47:0] BC   = 48'hFFFFFFFFFFFF;
  localparam logic [47:0] MC1  = 48'h0000FB5E0001;

  task automatic t_reset();
    check(vd_valid === 1'b0 && vd_accept === 1'b0, "R11 reset verdict", vd_valid, 0);
    check(in_ready === 1'b1, "R1 ready high", in_ready, 1);
  endtask

  task automatic t_default();
    set_sta(STA);
    wr(3'd0, 32'h0);
    frame(STA, 0, 1, "R8 station match");
    frame(UNI2, 0, 0, "R8 station mismatch");
    frame(BC, 0, 1, "R9 broadcast accepted");
    frame(MC1, 0, 0, "R9 multicast rejected no mode");
    frame(STA, 3, 1, "R1 gaps between bytes");
    check(in_ready === 1'b1, "R1 ready during traffic", in_ready, 1);
  endtask

  task automatic t_bcast_off();
    wr(3'd0, 32'h8);
    frame(BC, 0, 0, "R9 broadcast disabled");
    frame(STA, 0, 1, "R8 match with bcast off");
  endtask

  task automatic t_promisc();
    wr(3'd0, 32'h9);
    frame(UNI2, 0, 1, "R5 promisc unicast");
    frame(MC1, 0, 1, "R5 promisc multicast");
    frame(BC, 0, 1, "R5 promisc broadcast");
  endtask

  task automatic t_allmulti();
    wr(3'd0, 32'h2);
    frame(MC1, 0, 1, "R6 allmulti multicast");
    frame(48'h123456789A03, 0, 1, "R6 allmulti other multicast");
    frame(UNI2, 0, 0, "R6 allmulti unicast mismatch");
  endtask

  task automatic t_hash();
    wr(3'd0, 32'h4);
    for (int k = 0; k < 6; k++) begin
      logic [47:0] a;
      logic [5:0] ix;
      logic [31:0] one;
      a = {8'h11, 8'h22, 8'h33, 8'(k * 37), 8'h5E, 8'h01};
      ix = crc_of(a)[31:26];
      one = 32'h1 << ix[4:0];
      if (ix[5]) begin wr(3'd4, one); wr(3'd3, 32'h0); end
      else       begin wr(3'd3, one); wr(3'd4, 32'h0); end
      frame(a, 0, 1, "R4 R7 hash bin set");
      if (ix[5]) begin wr(3'd3, one); wr(3'd4, 32'h0); end
      else       begin wr(3'd4, one); wr(3'd3, 32'h0); end
      frame(a, 0, 0, "R4 R7 bin in other register");
      wr(3'd3, ~32'h0); wr(3'd4, ~32'h0);
      if (ix[5]) wr(3'd4, ~one); else wr(3'd3, ~one);
      frame_m(a, "R7 all bins but this one");
    end
    frame(STA, 0, 1, "R8 match in hash mode");
    frame(UNI2, 0, 0, "R8 mismatch in hash mode");
  endtask

  task automatic t_restart();
    int p0;
    wr(3'd0, 32'h0);
    p0 = pulses;
    for (int b = 0; b < 4; b++) put(UNI2[8*b +: 8], b == 0);
    for (int b = 0; b < 6; b++) put(STA[8*b +: 8], b == 0);
    finish(1, "R2 restart mid address");
    check(pulses == p0 + 1, "R2 abandoned address silent", pulses - p0, 1);
    p0 = pulses;
    for (int b = 0; b < 5; b++) put(8'hA5, 0);
    idle(2);
    check(pulses == p0, "R2 body bytes ignored", pulses - p0, 0);
  endtask

  task automatic t_midwrite();
    wr(3'd0, 32'h0);
    for (int b = 0; b < 3; b++) put(UNI2[8*b +: 8], b == 0);
    wr(3'd0, 32'h1);
    for (int b = 3; b < 6; b++) put(UNI2[8*b +: 8], 0);
    finish(0, "R10 write mid address deferred");
    frame(UNI2, 0, 1, "R10 write applied next frame");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    put(8'h12, 0);
    idle(2);
    check(pulses == 0, "R2 no sof since reset", pulses, 0);
    @(negedge clk); rst_n = 1;
    idle(2);
    check(pulses == 0, "R2 idle after reset", pulses, 0);
    t_default();
    t_bcast_off();
    t_promisc();
    t_allmulti();
    t_hash();
    t_restart();
    t_midwrite();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule